// File: doc/BRIEF.md
# External Memory Bank Select Controller

This block sits at the edge of a chip's external port and converts one internal access request at a time into a bus cycle toward off-chip memory or peripherals. The top bits of the 32-bit address are compared against a fixed region tag. When they match, the next address bits choose one of several banks, and the matching active-low bank select is driven for the whole cycle. Each bank carries its own wait count and acknowledge mode. A slow device can therefore be timed purely by counting, purely by its acknowledge pin, or by both. In the acknowledge-driven modes a cycle can last without bound.

Every bus cycle has the same shape. One setup cycle presents the address and the select. The read or write strobe then stays low for as many cycles as the bank's timing demands. One hold cycle follows with the strobe high and the select still driven. For reads, data is captured on the last strobe cycle and returned together with a one-clock done pulse. A narrow-bus option, chosen per request, limits the data path to its low 32 bits.

Top module: `extbus_bank_ctrl`

## Requirements
- R1: A request (`req_valid` high) is accepted only in a cycle where `req_ready` is high. `req_ready` is high only while no bus cycle is in progress. Requests presented during a bus cycle are ignored and start no further cycle.
- R2: An address is external when bits [31:28] equal 4'h1. For an external address, bank b = address bits [27:26], and `ext_bank_sel_n[b]` is driven low while the other selects stay high. An address outside the region drives no select low.
- R3: Each accepted request produces exactly three phases, starting the clock after acceptance. First comes one setup cycle, with the address on `ext_addr`, the select driven and both strobes high. Next come L strobe cycles. Last comes one hold cycle, with the strobes high and the select and address unchanged. The cycle after the hold is idle, with `req_ready` high.
- R4: Bank b's wait count is `bank_wait[3*b+2:3*b]`. In mode 2'b00 (count only), L = 1 + wait count, and `ext_ack` has no effect.
- R5: Bank b's mode is `bank_mode[2*b+1:2*b]`. In mode 2'b01 (acknowledge only), the strobe ends after the first strobe cycle in which `ext_ack` is high, so L >= 1.
- R6: In modes 2'b10 and 2'b11 (count and acknowledge), the strobe ends after the first strobe cycle i (counting from 1) with i >= 1 + wait count and `ext_ack` high.
- R7: An address outside the region always uses L = 1 and ignores `ext_ack`.
- R8: The following are captured when the request is accepted: wait count, mode, `narrow_mode`, address and write data. Changing them during the cycle has no effect on that cycle.
- R9: For a read, `ext_rd_n` is low exactly during the strobe cycles and `ext_wr_n` stays high. `ext_data_in` is captured on the last strobe cycle. `done` is high for exactly the hold cycle, and `rd_data` holds the captured data while `done` is high.
- R10: For a write, `ext_wr_n` is low exactly during the strobe cycles. `ext_data_oe` is high from setup through hold, and `ext_data_out` carries the write data. `done` pulses in the hold cycle.
- R11: With `narrow_mode` high at acceptance, bits [47:32] of `ext_data_out` and of `rd_data` are zero.
- R12: During reset and when idle: all selects are high, both strobes are high, `ext_data_oe` is low, `done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_addr | input | 32 | Access address |
| req_wdata | input | 48 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| narrow_mode | input | 1 | Use only the low 32 data bits |
| bank_wait | input | 12 | Per-bank 3-bit wait counts |
| bank_mode | input | 8 | Per-bank 2-bit acknowledge modes |
| ext_ack | input | 1 | External device acknowledge |
| ext_data_in | input | 48 | External read data |
| req_ready | output | 1 | Controller idle, request can be taken |
| ext_addr | output | 32 | External address bus |
| ext_data_out | output | 48 | External write data |
| ext_data_oe | output | 1 | Write data drive enable |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_bank_sel_n | output | 4 | Active-low bank selects |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 48 | Captured read data |

## Verification
The hardest situation to reach is a bank reconfiguration, or a fresh request, that lands in the middle of a long acknowledge-stretched strobe. This has to be shown to leave the running cycle alone. The stimulus holds `ext_ack` low while the strobe runs. It then rewrites every bank's wait count and mode, flips `narrow_mode` and keeps a different request asserted. Only after that does it release the acknowledge on a chosen strobe cycle. A second hard corner is the combined mode, where the count and the acknowledge can each be the later of the two events. The bench drives acknowledge both earlier and later than the count expiry, so that each case decides the strobe length.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      AM_COUNT    = 2'b00,
      AM_ACK      = 2'b01,
      AM_BOTH     = 2'b10,
      AM_BOTH_ALT = 2'b11
   } ack_mode_e;

   // Decides whether the current strobe cycle is the last one.
   function automatic logic strobe_ends(input logic [1:0] mode,
                                        input logic       count_met,
                                        input logic       ack);
      logic r;
      case (mode)
         AM_COUNT: r = count_met;
         AM_ACK:   r = ack;
         default:  r = count_met & ack;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/extbus_bank_decode.sv
module extbus_bank_decode #(
   parameter int HI_W      = 6,
   parameter int BANK_BITS = 2,
   parameter int EXT_TAG   = 1
) (
   input  logic [HI_W-1:0]          addr_hi,
   output logic                     in_region,
   output logic [BANK_BITS-1:0]     bank_idx,
   output logic [(1<<BANK_BITS)-1:0] sel_onehot
);
   localparam int NUM_BANKS = 1 << BANK_BITS;
   localparam int TAG_W     = HI_W - BANK_BITS;

   if (TAG_W < 1) begin : g_bad_tag
      $error("extbus_bank_decode: no address bits left for the region tag");
   end

   assign in_region = (addr_hi[HI_W-1:BANK_BITS] == TAG_W'(EXT_TAG));
   assign bank_idx  = addr_hi[BANK_BITS-1:0];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
      assign sel_onehot[b] = in_region && (bank_idx == BANK_BITS'(b));
   end
endmodule

// File: rtl/extbus_cfg_select.sv
module extbus_cfg_select #(
   parameter int NUM_BANKS = 4,
   parameter int BANK_BITS = 2,
   parameter int WAIT_W    = 3
) (
   input  logic [NUM_BANKS*WAIT_W-1:0] wait_flat,
   input  logic [NUM_BANKS*2-1:0]      mode_flat,
   input  logic [BANK_BITS-1:0]        bank_idx,
   input  logic                        in_region,
   output logic [WAIT_W-1:0]           wait_sel,
   output logic [1:0]                  mode_sel
);
   import extbus_pkg::*;

   logic [WAIT_W-1:0] wait_arr [NUM_BANKS];
   logic [1:0]        mode_arr [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_unpack
      assign wait_arr[b] = wait_flat[b*WAIT_W +: WAIT_W];
      assign mode_arr[b] = mode_flat[b*2 +: 2];
   end

   // Out-of-region accesses run the shortest count-only cycle.
   always_comb begin
      if (in_region) begin
         wait_sel = wait_arr[bank_idx];
         mode_sel = mode_arr[bank_idx];
      end else begin
         wait_sel = '0;
         mode_sel = AM_COUNT;
      end
   end
endmodule

// File: rtl/extbus_strobe_timer.sv
module extbus_strobe_timer #(
   parameter int WAIT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              run,
   input  logic [WAIT_W-1:0] wait_lim,
   input  logic [1:0]        mode,
   input  logic              ack,
   output logic              last
);
   import extbus_pkg::*;

   logic [WAIT_W-1:0] elapsed;
   logic              count_met;

   assign count_met = (elapsed >= wait_lim);
   assign last      = run && strobe_ends(mode, count_met, ack);

   // Counts completed strobe cycles, saturating once the limit is met.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed <= '0;
      end else if (start) begin
         elapsed <= '0;
      end else if (run && !count_met) begin
         elapsed <= elapsed + 1'b1;
      end
   end
endmodule

// File: rtl/extbus_bank_ctrl.sv
module extbus_bank_ctrl #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 48,
   parameter int NARROW_W  = 32,
   parameter int NUM_BANKS = 4,
   parameter int BANK_LSB  = 26,
   parameter int WAIT_W    = 3,
   parameter int EXT_TAG   = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [DATA_W-1:0]           req_wdata,
   input  logic                        req_write,
   input  logic                        narrow_mode,
   input  logic [NUM_BANKS*WAIT_W-1:0] bank_wait,
   input  logic [NUM_BANKS*2-1:0]      bank_mode,
   input  logic                        ext_ack,
   input  logic [DATA_W-1:0]           ext_data_in,
   output logic                        req_ready,
   output logic [ADDR_W-1:0]           ext_addr,
   output logic [DATA_W-1:0]           ext_data_out,
   output logic                        ext_data_oe,
   output logic                        ext_rd_n,
   output logic                        ext_wr_n,
   output logic [NUM_BANKS-1:0]        ext_bank_sel_n,
   output logic                        done,
   output logic [DATA_W-1:0]           rd_data
);
   import extbus_pkg::*;

   localparam int BANK_BITS = $clog2(NUM_BANKS);
   localparam int HI_W      = ADDR_W - BANK_LSB;

   if (NUM_BANKS < 2 || (1 << BANK_BITS) != NUM_BANKS) begin : g_bad_banks
      $error("extbus_bank_ctrl: NUM_BANKS must be a power of two >= 2");
   end
   if (BANK_LSB + BANK_BITS >= ADDR_W) begin : g_bad_lsb
      $error("extbus_bank_ctrl: bank field leaves no region tag bits");
   end
   if (NARROW_W < 1 || NARROW_W > DATA_W) begin : g_bad_narrow
      $error("extbus_bank_ctrl: NARROW_W must lie in 1..DATA_W");
   end
   if (WAIT_W < 1) begin : g_bad_wait
      $error("extbus_bank_ctrl: WAIT_W must be at least 1");
   end

   // ---------------- address decode and configuration pick ----------------
   logic                 dec_in_region;
   logic [BANK_BITS-1:0] dec_bank;
   logic [NUM_BANKS-1:0] dec_sel;
   logic [WAIT_W-1:0]    cfg_wait;
   logic [1:0]           cfg_mode;

   extbus_bank_decode #(
      .HI_W      (HI_W),
      .BANK_BITS (BANK_BITS),
      .EXT_TAG   (EXT_TAG)
   ) u_decode (
      .addr_hi    (req_addr[ADDR_W-1:BANK_LSB]),
      .in_region  (dec_in_region),
      .bank_idx   (dec_bank),
      .sel_onehot (dec_sel)
   );

   extbus_cfg_select #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_BITS (BANK_BITS),
      .WAIT_W    (WAIT_W)
   ) u_cfg (
      .wait_flat (bank_wait),
      .mode_flat (bank_mode),
      .bank_idx  (dec_bank),
      .in_region (dec_in_region),
      .wait_sel  (cfg_wait),
      .mode_sel  (cfg_mode)
   );

   // ---------------- data width variant ----------------
   phase_e               phase;
   logic                 lat_narrow;
   logic [DATA_W-1:0]    wdata_fit;
   logic [DATA_W-1:0]    rdata_fit;

   if (NARROW_W < DATA_W) begin : g_narrow
      localparam int PAD_W = DATA_W - NARROW_W;
      assign wdata_fit = narrow_mode ? {{PAD_W{1'b0}}, req_wdata[NARROW_W-1:0]} : req_wdata;
      assign rdata_fit = lat_narrow  ? {{PAD_W{1'b0}}, ext_data_in[NARROW_W-1:0]} : ext_data_in;
   end else begin : g_full
      assign wdata_fit = req_wdata;
      assign rdata_fit = ext_data_in;
   end

   // ---------------- cycle sequencer ----------------
   logic                 accept;
   logic                 strobe_last;
   logic                 lat_write;
   logic [NUM_BANKS-1:0] lat_sel;
   logic [WAIT_W-1:0]    lat_wait;
   logic [1:0]           lat_mode;
   logic [DATA_W-1:0]    lat_wdata;
   logic [ADDR_W-1:0]    lat_addr;
   logic [DATA_W-1:0]    rd_q;
   logic                 done_q;

   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_ready && req_valid;

   extbus_strobe_timer #(
      .WAIT_W (WAIT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .run      (phase == PH_STROBE),
      .wait_lim (lat_wait),
      .mode     (lat_mode),
      .ack      (ext_ack),
      .last     (strobe_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         lat_write  <= 1'b0;
         lat_narrow <= 1'b0;
         lat_sel    <= '0;
         lat_wait   <= '0;
         lat_mode   <= '0;
         lat_wdata  <= '0;
         lat_addr   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (accept) begin
                  phase      <= PH_SETUP;
                  lat_write  <= req_write;
                  lat_narrow <= narrow_mode;
                  lat_sel    <= dec_sel;
                  lat_wait   <= cfg_wait;
                  lat_mode   <= cfg_mode;
                  lat_wdata  <= wdata_fit;
                  lat_addr   <= req_addr;
               end
            end
            PH_SETUP:  phase <= PH_STROBE;
            PH_STROBE: if (strobe_last) phase <= PH_HOLD;
            PH_HOLD:   phase <= PH_IDLE;
            default:   phase <= PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         rd_q   <= '0;
      end else begin
         done_q <= strobe_last;
         if (strobe_last && !lat_write) begin
            rd_q <= rdata_fit;
         end
      end
   end

   // ---------------- pin drive ----------------
   always_comb begin
      ext_bank_sel_n = '1;
      if (phase != PH_IDLE) begin
         ext_bank_sel_n = ~lat_sel;
      end
   end

   assign ext_rd_n     = !((phase == PH_STROBE) && !lat_write);
   assign ext_wr_n     = !((phase == PH_STROBE) &&  lat_write);
   assign ext_data_oe  = (phase != PH_IDLE) && lat_write;
   assign ext_data_out = lat_wdata;
   assign ext_addr     = lat_addr;
   assign done         = done_q;
   assign rd_data      = rd_q;

endmodule

// File: rtl/extbus_bank_ctrl_chk.sv
module extbus_bank_ctrl_chk #(
   parameter int NUM_BANKS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_ready,
   input logic                 ext_rd_n,
   input logic                 ext_wr_n,
   input logic                 ext_data_oe,
   input logic [NUM_BANKS-1:0] ext_bank_sel_n,
   input logic                 done
);
   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ext_bank_sel_n)); // R2

   AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ext_rd_n && !ext_wr_n)); // R9

   AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_STROBE_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ext_rd_n) || $rose(ext_wr_n)) |-> done); // R3

   AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $past(!req_ready)) |-> $stable(ext_bank_sel_n)); // R3

   AST_SETUP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_ready) |-> (ext_rd_n && ext_wr_n)); // R3

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ext_rd_n && ext_wr_n && !ext_data_oe && (&ext_bank_sel_n) && !done)); // R12
endmodule

bind extbus_bank_ctrl extbus_bank_ctrl_chk #(
   .NUM_BANKS (NUM_BANKS)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_ready      (req_ready),
   .ext_rd_n       (ext_rd_n),
   .ext_wr_n       (ext_wr_n),
   .ext_data_oe    (ext_data_oe),
   .ext_bank_sel_n (ext_bank_sel_n),
   .done           (done)
);

// File: tb/extbus_bank_ctrl_bench.sv
`timescale 1ns/1ps
module extbus_bank_ctrl_bench;
   localparam int NB = 4;
   localparam int WW = 3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write, narrow_mode, ext_ack;
   logic [31:0] req_addr;
   logic [47:0] req_wdata, ext_data_in;
   logic [NB*WW-1:0] bank_wait;
   logic [NB*2-1:0]  bank_mode;
   logic        req_ready, ext_data_oe, ext_rd_n, ext_wr_n, done;
   logic [31:0] ext_addr;
   logic [47:0] ext_data_out, rd_data;
   logic [NB-1:0] ext_bank_sel_n;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;
   int cfg_w [NB];
   int cfg_m [NB];

   always #2.5 clk = ~clk;

   extbus_bank_ctrl u_extbus_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_write(req_write), .narrow_mode(narrow_mode),
      .bank_wait(bank_wait), .bank_mode(bank_mode), .ext_ack(ext_ack),
      .ext_data_in(ext_data_in), .req_ready(req_ready), .ext_addr(ext_addr),
      .ext_data_out(ext_data_out), .ext_data_oe(ext_data_oe), .ext_rd_n(ext_rd_n),
      .ext_wr_n(ext_wr_n), .ext_bank_sel_n(ext_bank_sel_n), .done(done),
      .rd_data(rd_data)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic apply_cfg(input int w [NB], input int m [NB]);
      for (int b = 0; b < NB; b++) begin
         bank_wait[b*WW +: WW] = WW'(w[b]);
         bank_mode[b*2 +: 2]   = 2'(m[b]);
      end
   endtask

   task automatic check_idle(input string tag);
      chk({tag, " ready"}, 64'(req_ready), 64'd1);
      chk({tag, " sel"}, 64'(ext_bank_sel_n), 64'hF);
      chk({tag, " rd_n"}, 64'(ext_rd_n), 64'd1);
      chk({tag, " wr_n"}, 64'(ext_wr_n), 64'd1);
      chk({tag, " oe"}, 64'(ext_data_oe), 64'd0);
      chk({tag, " done"}, 64'(done), 64'd0);
   endtask

   // Reference model: builds the expected waveform from the requirements and
   // compares it against the ports on every clock of the transaction.
   task automatic txn(input logic [31:0] a, input logic [47:0] wd, input bit wr,
                      input bit nar, input int k, input logic [47:0] rdin,
                      input bit disturb, input string tag);
      bit          inreg;
      int          b, w, m, len, total;
      logic [3:0]  seln;
      logic [47:0] mask;
      int          w_save [NB];
      int          m_save [NB];
      int          w_junk [NB];
      int          m_junk [NB];
      inreg = (a[31:28] == 4'h1);
      b     = int'(a[27:26]);
      w     = inreg ? cfg_w[b] : 0;
      m     = inreg ? cfg_m[b] : 0;
      seln  = inreg ? ~(4'b0001 << b) : 4'hF;
      mask  = nar ? 48'h0000_FFFF_FFFF : 48'hFFFF_FFFF_FFFF;
      if (!inreg)      len = 1;
      else if (m == 0) len = 1 + w;
      else if (m == 1) len = k;
      else             len = (k > 1 + w) ? k : 1 + w;
      total = len + 2;
      w_save = cfg_w;
      m_save = cfg_m;
      for (int i = 0; i < NB; i++) begin w_junk[i] = 7; m_junk[i] = 1; end

      chk({tag, " R1 ready before request"}, 64'(req_ready), 64'd1);
      req_valid   = 1'b1;
      req_addr    = a;
      req_wdata   = wd;
      req_write   = wr;
      narrow_mode = nar;
      ext_data_in = rdin;
      ext_ack     = 1'b0;

      for (int c = 0; c < total; c++) begin
         bit strobe, exp_done;
         @(negedge clk);
         strobe   = (c >= 1) && (c <= len);
         exp_done = (c == len + 1);
         ext_ack  = strobe && (c >= k);
         req_valid = disturb && (c < total - 1);
         if (disturb) begin
            req_addr    = ~a;
            req_write   = ~wr;
            narrow_mode = ~nar;
            if (c == 1)       apply_cfg(w_junk, m_junk);
            if (c == len + 1) apply_cfg(w_save, m_save);
         end else begin
            req_valid = 1'b0;
         end
         chk({tag, " R3 ready low"}, 64'(req_ready), 64'd0);
         chk({tag, " R2 select"}, 64'(ext_bank_sel_n), 64'(seln));
         chk({tag, " R3 address"}, 64'(ext_addr), 64'(a));
         chk({tag, " R9 rd_n"}, 64'(ext_rd_n), 64'(!(strobe && !wr)));
         chk({tag, " R10 wr_n"}, 64'(ext_wr_n), 64'(!(strobe && wr)));
         chk({tag, " R10 oe"}, 64'(ext_data_oe), 64'(wr));
         chk({tag, " R9 done"}, 64'(done), 64'(exp_done));
         if (wr)
            chk({tag, " R11 write data"}, 64'(ext_data_out), 64'(wd & mask));
         if (exp_done && !wr)
            chk({tag, " R9 read data"}, 64'(rd_data), 64'(rdin & mask));
      end
      @(negedge clk);
      req_valid = 1'b0;
      ext_ack   = 1'b0;
      check_idle({tag, " R1 idle after hold"});
   endtask

   initial begin
      rst_n = 1'b0;
      req_valid = 1'b0; req_write = 1'b0; narrow_mode = 1'b0; ext_ack = 1'b0;
      req_addr = '0; req_wdata = '0; ext_data_in = '0;
      cfg_w = '{0, 5, 2, 2};
      cfg_m = '{0, 0, 1, 2};
      apply_cfg(cfg_w, cfg_m);
      repeat (3) @(negedge clk);
      check_idle("R12 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R12 after reset");

      // R4 count-only, zero waits, read on bank 0
      txn(32'h1000_0040, 48'h0, 1'b0, 1'b0, 99, 48'hA5A5_1234_5678, 1'b0, "R4 b0 w0 read");
      // R4 count-only, wait 5, write on bank 1
      txn(32'h1400_0100, 48'hBEEF_CAFE_0011, 1'b1, 1'b0, 99, 48'h0, 1'b0, "R4 b1 w5 write");
      // R5 acknowledge-only, ack on strobe cycle 4
      txn(32'h1800_0008, 48'h0, 1'b0, 1'b0, 4, 48'h1111_2222_3333, 1'b0, "R5 b2 ack at 4");
      // R5 acknowledge-only, ack on the first strobe cycle
      txn(32'h1800_000C, 48'h0123_4567_89AB, 1'b1, 1'b0, 1, 48'h0, 1'b0, "R5 b2 ack at 1");
      // R6 combined, ack later than count expiry
      txn(32'h1C00_0010, 48'h0, 1'b0, 1'b0, 6, 48'h7777_8888_9999, 1'b0, "R6 b3 ack late");
      // R6 combined, ack early: count decides (length 3)
      txn(32'h1C00_0014, 48'h0, 1'b0, 1'b0, 1, 48'h4444_5555_6666, 1'b0, "R6 b3 ack early");
      // R7 outside the region: no select, one strobe cycle
      txn(32'h2400_0000, 48'hFFFF_0000_FFFF, 1'b1, 1'b0, 99, 48'h0, 1'b0, "R7 out of region");
      txn(32'h0C00_0020, 48'h0, 1'b0, 1'b0, 99, 48'hDEAD_BEEF_F00D, 1'b0, "R7 low region read");
      // R11 narrow data path on read and write
      txn(32'h1000_0030, 48'h0, 1'b0, 1'b1, 99, 48'hFFFF_8765_4321, 1'b0, "R11 narrow read");
      txn(32'h1400_0034, 48'hABCD_1357_2468, 1'b1, 1'b1, 99, 48'h0, 1'b0, "R11 narrow write");
      // R4 count-only ignores an acknowledge that is high from the start
      cfg_w[0] = 3;
      apply_cfg(cfg_w, cfg_m);
      txn(32'h1000_0050, 48'h0, 1'b0, 1'b0, 1, 48'h0F0F_0F0F_0F0F, 1'b0, "R4 ack ignored");
      // R8 and R1: config, narrow flag and new requests change mid-cycle
      txn(32'h1800_0060, 48'h0, 1'b0, 1'b0, 5, 48'hC0C0_A0A0_B0B0, 1'b1, "R8 R1 disturbed ack");
      txn(32'h1C00_0064, 48'h9999_AAAA_BBBB, 1'b1, 1'b1, 4, 48'h0, 1'b1, "R8 R1 disturbed both");
      txn(32'h1000_0068, 48'h0, 1'b0, 1'b0, 1, 48'h1357_9BDF_0246, 1'b1, "R8 R1 disturbed count");

      repeat (2) @(negedge clk);
      check_idle("R1 final idle");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule